// File: doc/BRIEF.md
# Converter Power Mode Controller

This block decides the power state of a data converter and drives its power-down and output-enable controls. It accepts low-power requests from two sources. In serial programming mode, a mode register supplies a sleep bit and a nap bit. In parallel programming mode, a single dedicated pin supplies sleep, and nap cannot be requested. Sleep turns off the converter core and its references. Nap turns off only the core, so the references stay up and the converter wakes faster.

When a power-down request is withdrawn, the block powers everything back on and holds the ready flag low until the data can be trusted again:
- After nap, it waits a fixed number of sample-clock cycles.
- After nap with DC-accurate settling requested, it also waits a number of microsecond ticks.
- After sleep, it waits a much longer number of microsecond ticks.

A new request arriving during any of these waits cancels the wake and returns the block to the requested low-power state. A separate output-disable request tri-states all data outputs and the output clock, whatever the power state.

Top module: `cpm_ctrl`

## Requirements
- R1: During and immediately after synchronous reset, ready=1, core_pd=0, ref_pd=0 and out_oe=1.
- R2: In serial mode (prog_serial=1), when reg_sleep=1 is sampled at a rising edge, core_pd=1, ref_pd=1 and ready=0 from that edge on.
- R3: In serial mode, when reg_nap=1 with reg_sleep=0 is sampled at a rising edge, core_pd=1, ref_pd=0 and ready=0 from that edge on.
- R4: A sleep request and a nap request present together always give the sleep state (ref_pd=1).
- R5: The first rising edge after a nap request is withdrawn clears core_pd. With dc_settle_en=0, ready rises on exactly the (NAP_WAKE_CYC+1)-th rising edge after the withdrawal.
- R6: With dc_settle_en=1, once the nap cycle count completes, ready stays low until NAP_SETTLE_US further us_tick pulses have been counted.
- R7: After a sleep request is withdrawn, both power-downs clear on the next edge. Ready rises on the edge after the SLEEP_WAKE_US-th us_tick pulse counted in the wake state.
- R8: A sleep or nap request that arrives during any wake wait re-enters that low-power state on the next edge. A later wake restarts its count from zero.
- R9: In parallel mode (prog_serial=0), pin_sleep=1 selects sleep, and reg_sleep and reg_nap have no effect.
- R10: In serial mode, pin_sleep has no effect.
- R11: out_oe takes the value !reg_out_off on every rising edge, independent of the power state.
- R12: Ready is low in every low-power and wake state. It never rises directly out of a low-power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| prog_serial | input | 1 | 1 = serial programming mode, 0 = parallel pin mode |
| reg_sleep | input | 1 | Sleep bit from the mode register (serial mode) |
| reg_nap | input | 1 | Nap bit from the mode register (serial mode) |
| pin_sleep | input | 1 | Sleep pin (parallel mode) |
| reg_out_off | input | 1 | Request to tri-state data outputs and output clock |
| dc_settle_en | input | 1 | Add the reference settle wait after a nap wake |
| core_pd | output | 1 | Power down the converter core |
| ref_pd | output | 1 | Power down the reference circuits |
| out_oe | output | 1 | Output driver enable for data and output clock (0 = high impedance) |
| ready | output | 1 | Converted data is valid |

## Verification
The assertions check the following on every cycle:
- The references are never down while the core is up.
- Sleep wins over nap.
- A nap state can only follow a serial-mode nap request.
- The output enable tracks the disable request one edge later.
- Ready only ever rises out of a wake state.
- The nap wake wait lasts exactly its cycle count.

The bench scenarios are needed for the tick-based wait windows after sleep and after settle, the abort of a wake and restart of the count, and the ignoring of the inactive source in each programming mode. Each of these needs a specific sequence of requests to show.

// File: rtl/cpm_pkg.sv
// Package: shared state type for the converter power mode controller.
// Assumes: one state register, encoded in three bits.
package cpm_pkg;

    typedef enum logic [2:0] {
        PM_ACTIVE      = 3'd0,
        PM_NAP         = 3'd1,
        PM_SLEEP       = 3'd2,
        PM_WAKE_NAP    = 3'd3,
        PM_WAKE_SETTLE = 3'd4,
        PM_WAKE_SLEEP  = 3'd5
    } pm_state_e;

endpackage

// File: rtl/cpm_req_sel.sv
// Module: cpm_req_sel
// Picks the effective sleep and nap requests for the current programming
// mode. Serial mode uses the register bits; parallel mode uses the sleep pin
// and cannot nap. Sleep masks nap so the two are never both set.
// Assumes: the inputs are already synchronous to clk.
module cpm_req_sel (
    input  logic prog_serial,
    input  logic reg_sleep,
    input  logic reg_nap,
    input  logic pin_sleep,
    output logic sleep_req,
    output logic nap_req
);

    // Mode select with sleep priority.
    always_comb begin
        sleep_req = prog_serial ? reg_sleep : pin_sleep;
        nap_req   = prog_serial & reg_nap & ~sleep_req;
    end

endmodule

// File: rtl/cpm_wait_timer.sv
// Module: cpm_wait_timer
// A single saturating counter shared by every wake wait. clr restarts it;
// inc advances it by one. done is set once the count reaches limit.
// Assumes: the caller pulses clr on every state change.
module cpm_wait_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Count with restart and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Compare against the limit of the current wait.
    always_comb begin
        done = (cnt_q >= limit);
    end

endmodule

// File: rtl/cpm_fsm.sv
// Module: cpm_fsm
// Power state machine. Moves between active, the two low-power states and
// the three wake waits, and selects the limit and count source of the shared
// wait timer. Outputs are decoded from the state register.
// Assumes: sleep_req and nap_req are never set together.
module cpm_fsm
    import cpm_pkg::*;
#(
    parameter int NAP_WAKE_CYC  = 100,
    parameter int NAP_SETTLE_US = 50,
    parameter int SLEEP_WAKE_US = 2000,
    parameter int CNT_W         = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             nap_req,
    input  logic             us_tick,
    input  logic             dc_settle_en,
    input  logic             tmr_done,
    output logic             tmr_clr,
    output logic             tmr_inc,
    output logic [CNT_W-1:0] tmr_limit,
    output pm_state_e        state,
    output logic             core_pd,
    output logic             ref_pd,
    output logic             ready
);

    localparam logic [CNT_W-1:0] LIM_NAP    = CNT_W'(NAP_WAKE_CYC - 1);
    localparam logic [CNT_W-1:0] LIM_SETTLE = CNT_W'(NAP_SETTLE_US);
    localparam logic [CNT_W-1:0] LIM_SLEEP  = CNT_W'(SLEEP_WAKE_US);

    pm_state_e st_q;
    pm_state_e st_d;

    // Next-state logic: a request always wins, otherwise wait or wake.
    always_comb begin
        st_d = st_q;
        if (sleep_req) begin
            st_d = PM_SLEEP;
        end else if (nap_req) begin
            st_d = PM_NAP;
        end else begin
            unique case (st_q)
                PM_ACTIVE:      st_d = PM_ACTIVE;
                PM_NAP:         st_d = PM_WAKE_NAP;
                PM_SLEEP:       st_d = PM_WAKE_SLEEP;
                PM_WAKE_NAP:    if (tmr_done) st_d = dc_settle_en ? PM_WAKE_SETTLE : PM_ACTIVE;
                PM_WAKE_SETTLE: if (tmr_done) st_d = PM_ACTIVE;
                PM_WAKE_SLEEP:  if (tmr_done) st_d = PM_ACTIVE;
                default:        st_d = PM_ACTIVE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PM_ACTIVE;
        end else begin
            st_q <= st_d;
        end
    end

    // Timer control: restart on every state change, source and limit by state.
    always_comb begin
        tmr_clr   = (st_d != st_q);
        tmr_inc   = 1'b0;
        tmr_limit = '0;
        unique case (st_q)
            PM_WAKE_NAP: begin
                tmr_inc   = 1'b1;
                tmr_limit = LIM_NAP;
            end
            PM_WAKE_SETTLE: begin
                tmr_inc   = us_tick;
                tmr_limit = LIM_SETTLE;
            end
            PM_WAKE_SLEEP: begin
                tmr_inc   = us_tick;
                tmr_limit = LIM_SLEEP;
            end
            default: begin
                tmr_inc   = 1'b0;
                tmr_limit = '0;
            end
        endcase
    end

    // Output decode from the state register.
    always_comb begin
        state   = st_q;
        core_pd = (st_q == PM_NAP) || (st_q == PM_SLEEP);
        ref_pd  = (st_q == PM_SLEEP);
        ready   = (st_q == PM_ACTIVE);
    end

endmodule

// File: rtl/cpm_ctrl.sv
// Module: cpm_ctrl (top)
// Converter power mode controller: request selection, power state machine,
// shared wake timer and the registered output enable.
// Assumes: us_tick is a one-cycle pulse synchronous to clk; NAP_WAKE_CYC >= 1.
module cpm_ctrl
    import cpm_pkg::*;
#(
    parameter int NAP_WAKE_CYC  = 100,
    parameter int NAP_SETTLE_US = 50,
    parameter int SLEEP_WAKE_US = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic prog_serial,
    input  logic reg_sleep,
    input  logic reg_nap,
    input  logic pin_sleep,
    input  logic reg_out_off,
    input  logic dc_settle_en,
    output logic core_pd,
    output logic ref_pd,
    output logic out_oe,
    output logic ready
);

    localparam int WAIT_A   = (NAP_WAKE_CYC > NAP_SETTLE_US) ? NAP_WAKE_CYC : NAP_SETTLE_US;
    localparam int WAIT_MAX = (WAIT_A > SLEEP_WAKE_US) ? WAIT_A : SLEEP_WAKE_US;
    localparam int CNT_W    = $clog2(WAIT_MAX + 1) + 1;

    logic             sleep_req;
    logic             nap_req;
    logic             tmr_clr;
    logic             tmr_inc;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_limit;
    pm_state_e        st;
    logic             oe_q;

    cpm_req_sel u_sel (
        .prog_serial (prog_serial),
        .reg_sleep   (reg_sleep),
        .reg_nap     (reg_nap),
        .pin_sleep   (pin_sleep),
        .sleep_req   (sleep_req),
        .nap_req     (nap_req)
    );

    cpm_fsm #(
        .NAP_WAKE_CYC  (NAP_WAKE_CYC),
        .NAP_SETTLE_US (NAP_SETTLE_US),
        .SLEEP_WAKE_US (SLEEP_WAKE_US),
        .CNT_W         (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req    (sleep_req),
        .nap_req      (nap_req),
        .us_tick      (us_tick),
        .dc_settle_en (dc_settle_en),
        .tmr_done     (tmr_done),
        .tmr_clr      (tmr_clr),
        .tmr_inc      (tmr_inc),
        .tmr_limit    (tmr_limit),
        .state        (st),
        .core_pd      (core_pd),
        .ref_pd       (ref_pd),
        .ready        (ready)
    );

    cpm_wait_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    // Output enable register, independent of the power state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b1;
        end else begin
            oe_q <= ~reg_out_off;
        end
    end

    assign out_oe = oe_q;

endmodule

// File: rtl/cpm_ctrl_chk.sv
// Module: cpm_ctrl_chk
// Property checker for cpm_ctrl, attached by bind at the end of this file.
// Assumes: clk and rst_n are the ones the top module uses.
module cpm_ctrl_chk
    import cpm_pkg::*;
#(
    parameter int NAP_WAKE_CYC = 100
) (
    input logic      clk,
    input logic      rst_n,
    input logic      prog_serial,
    input logic      reg_sleep,
    input logic      reg_nap,
    input logic      reg_out_off,
    input logic      core_pd,
    input logic      ref_pd,
    input logic      out_oe,
    input logic      ready,
    input pm_state_e st
);

    localparam int CW = $clog2(NAP_WAKE_CYC + 1) + 1;

    logic [CW-1:0] wn_cnt;

    // Count cycles spent in the nap wake wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wn_cnt <= '0;
        end else if (st == PM_WAKE_NAP) begin
            wn_cnt <= wn_cnt + 1'b1;
        end else begin
            wn_cnt <= '0;
        end
    end

    assert_refs_imply_core_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pd |-> core_pd);

    assert_sleep_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_serial && reg_sleep) |=> (ref_pd && core_pd && !ready));

    assert_nap_serial_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_pd && !ref_pd) |-> $past(prog_serial && reg_nap));

    assert_nap_wake_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st) == PM_WAKE_NAP) && ((st == PM_ACTIVE) || (st == PM_WAKE_SETTLE)))
        |-> ($past(wn_cnt) == CW'(NAP_WAKE_CYC - 1)));

    assert_oe_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_out_off |=> !out_oe);

    assert_oe_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_out_off |=> out_oe);

    assert_ready_from_wake_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (($past(st) == PM_WAKE_NAP) || ($past(st) == PM_WAKE_SETTLE)
                          || ($past(st) == PM_WAKE_SLEEP)));

endmodule

bind cpm_ctrl cpm_ctrl_chk #(
    .NAP_WAKE_CYC (NAP_WAKE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_serial (prog_serial),
    .reg_sleep   (reg_sleep),
    .reg_nap     (reg_nap),
    .reg_out_off (reg_out_off),
    .core_pd     (core_pd),
    .ref_pd      (ref_pd),
    .out_oe      (out_oe),
    .ready       (ready),
    .st          (st)
);

// File: tb/sim_cpm_ctrl.sv
// Directed bench for cpm_ctrl with shortened wait parameters.
module sim_cpm_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NWC        = 10;   // nap wake cycles
    localparam int NSU        = 5;    // settle ticks
    localparam int SWU        = 12;   // sleep wake ticks
    localparam int TP         = 4;    // cycles per us_tick

    logic clk = 1'b0;
    logic rst_n;
    logic us_tick = 1'b0;
    logic prog_serial, reg_sleep, reg_nap, pin_sleep, reg_out_off, dc_settle_en;
    logic core_pd, ref_pd, out_oe, ready;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    cpm_ctrl #(
        .NAP_WAKE_CYC  (NWC),
        .NAP_SETTLE_US (NSU),
        .SLEEP_WAKE_US (SWU)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .us_tick      (us_tick),
        .prog_serial  (prog_serial),
        .reg_sleep    (reg_sleep),
        .reg_nap      (reg_nap),
        .pin_sleep    (pin_sleep),
        .reg_out_off  (reg_out_off),
        .dc_settle_en (dc_settle_en),
        .core_pd      (core_pd),
        .ref_pd       (ref_pd),
        .out_oe       (out_oe),
        .ready        (ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Microsecond tick: one cycle high every TP cycles, driven at negedge.
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % TP;
            us_tick = (ph == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count edges after a withdrawal until ready; report state after first edge.
    task automatic wait_ready(output int n, output bit pd1, output bit rdy1);
        n = 0;
        pd1 = 1'b1;
        rdy1 = 1'b1;
        for (int i = 0; i < 400; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) begin
                pd1 = core_pd | ref_pd;
                rdy1 = ready;
            end
            if (ready) break;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        prog_serial = 1'b1; reg_sleep = 1'b0; reg_nap = 1'b0;
        pin_sleep = 1'b0; reg_out_off = 1'b0; dc_settle_en = 1'b0;
        step(4);
        chk(ready && !core_pd && !ref_pd && out_oe, "R1 in reset",
            {ready, core_pd, ref_pd, out_oe}, 4'b1001);
        rst_n = 1'b1;
        step(2);
        chk(ready && !core_pd && !ref_pd && out_oe, "R1 after reset",
            {ready, core_pd, ref_pd, out_oe}, 4'b1001);
    endtask

    task automatic t_sleep;
        int n; bit pd1, r1;
        reg_sleep = 1'b1;
        step(1);
        chk(core_pd && ref_pd && !ready, "R2 sleep entry", {core_pd, ref_pd, ready}, 3'b110);
        step(5);
        chk(!ready, "R12 ready low in sleep", ready, 0);
        reg_sleep = 1'b0;
        wait_ready(n, pd1, r1);
        chk(!pd1 && !r1, "R7 power up before wait", {pd1, r1}, 0);
        chk(n >= (SWU-1)*TP + 3 && n <= SWU*TP + 2, "R7 sleep wake window", n, SWU*TP);
    endtask

    task automatic t_nap;
        int n; bit pd1, r1;
        reg_nap = 1'b1;
        step(1);
        chk(core_pd && !ref_pd && !ready, "R3 nap entry", {core_pd, ref_pd, ready}, 3'b100);
        step(3);
        chk(!ready, "R12 ready low in nap", ready, 0);
        reg_nap = 1'b0;
        wait_ready(n, pd1, r1);
        chk(!pd1 && !r1, "R5 core up before wait", {pd1, r1}, 0);
        chk(n == NWC + 1, "R5 nap wake length", n, NWC + 1);
    endtask

    task automatic t_priority;
        reg_sleep = 1'b1; reg_nap = 1'b1;
        step(1);
        chk(ref_pd && core_pd, "R4 sleep over nap", {core_pd, ref_pd}, 3);
        reg_nap = 1'b0; step(2);
        reg_nap = 1'b1; step(2);
        chk(ref_pd, "R4 sleep held with nap", ref_pd, 1);
        reg_sleep = 1'b0; reg_nap = 1'b0;
        step(SWU*TP + 6);
        chk(ready, "R7 back to active", ready, 1);
    endtask

    task automatic t_settle;
        int n; bit pd1, r1;
        dc_settle_en = 1'b1;
        reg_nap = 1'b1;
        step(2);
        reg_nap = 1'b0;
        wait_ready(n, pd1, r1);
        chk(n >= NWC + (NSU-1)*TP + 3 && n <= NWC + NSU*TP + 2, "R6 settle window",
            n, NWC + NSU*TP);
        dc_settle_en = 1'b0;
    endtask

    task automatic t_abort;
        int n; bit pd1, r1;
        reg_sleep = 1'b1; step(2);
        reg_sleep = 1'b0; step(6);
        chk(!ready && !core_pd, "R8 in sleep wake", {ready, core_pd}, 0);
        reg_nap = 1'b1;
        step(1);
        chk(core_pd && !ref_pd && !ready, "R8 abort to nap", {core_pd, ref_pd, ready}, 3'b100);
        reg_nap = 1'b0;
        step(NWC/2);
        reg_sleep = 1'b1;
        step(1);
        chk(core_pd && ref_pd && !ready, "R8 abort to sleep", {core_pd, ref_pd, ready}, 3'b110);
        reg_sleep = 1'b0;
        reg_nap = 1'b1; step(1);
        reg_nap = 1'b0;
        wait_ready(n, pd1, r1);
        chk(n == NWC + 1, "R8 count restarts", n, NWC + 1);
    endtask

    task automatic t_parallel;
        int n; bit pd1, r1;
        prog_serial = 1'b0;
        reg_nap = 1'b1; step(3);
        chk(ready && !core_pd, "R9 reg_nap ignored", {ready, core_pd}, 2);
        reg_nap = 1'b0; reg_sleep = 1'b1; step(3);
        chk(ready && !core_pd && !ref_pd, "R9 reg_sleep ignored", {ready, core_pd, ref_pd}, 4);
        reg_sleep = 1'b0; pin_sleep = 1'b1; step(1);
        chk(core_pd && ref_pd && !ready, "R9 pin sleep", {core_pd, ref_pd, ready}, 3'b110);
        pin_sleep = 1'b0;
        wait_ready(n, pd1, r1);
        chk(n >= (SWU-1)*TP + 3 && n <= SWU*TP + 2, "R9 pin sleep wake", n, SWU*TP);
        prog_serial = 1'b1;
        pin_sleep = 1'b1; step(3);
        chk(ready && !core_pd && !ref_pd, "R10 pin ignored in serial",
            {ready, core_pd, ref_pd}, 4);
        pin_sleep = 1'b0;
    endtask

    task automatic t_oe;
        reg_out_off = 1'b1;
        step(1);
        chk(!out_oe && ready, "R11 disable while active", {out_oe, ready}, 1);
        reg_sleep = 1'b1; step(2);
        chk(!out_oe, "R11 disable held in sleep", out_oe, 0);
        reg_out_off = 1'b0; step(1);
        chk(out_oe && ref_pd, "R11 enable in sleep", {out_oe, ref_pd}, 3);
        reg_sleep = 1'b0;
        step(SWU*TP + 6);
        chk(ready && out_oe, "R11 active enabled", {ready, out_oe}, 3);
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_sleep();
        t_nap();
        t_priority();
        t_settle();
        t_abort();
        t_parallel();
        t_oe();
        finish_run();
    end

endmodule